// File: doc/BRIEF.md
# Host Command Mailbox Decoder

This block is a write-only mailbox that sits at one address in a core's memory map. Each 64-bit word written into it is treated as a command. The top byte of the word selects a device, the next byte selects a command, and the low 48 bits carry a payload. The block acts on two kinds of command and silently drops every other word.

The first kind is an exit request sent to the system-call proxy device. It raises a sticky exit flag and captures a 47-bit exit code. The flag stays set until reset. The second kind is a terminal output command. It hands one character to a valid/ready output stream.

The upstream address decoder must send only accesses that hit the mailbox address. Reads have no source data, because console input is not provided, so every read returns zero.

The character stream follows the usual back-pressure rules:
- Once `chr_valid` rises, `chr_data` stays fixed until a cycle in which `chr_ready` is high.
- The transfer happens on that clock edge, and `chr_valid` falls after it unless a new character is loaded.
- Only one character is held. A terminal output command that arrives while a character is still pending is discarded.
- A new character can therefore be loaded no earlier than the cycle after the transfer.

Top module: `hcmd_mailbox`

## Requirements
- R1: A write whose bits 63:56 equal 0x00 and whose bit 0 is 1 sets `exit_req` one cycle after the write. In that same cycle `exit_code` shows the written bits 47:1.
- R2: `exit_req` stays high until reset. After it is set, later exit writes do not change `exit_code`, so the first exit code is kept.
- R3: A write to device 0x00 whose bit 0 is 0 leaves `exit_req` and `exit_code` unchanged.
- R4: A write with device 0x01 and command 0x01 (bits 55:48) made while no character is pending raises `chr_valid` one cycle later. `chr_data` then holds the written bits 7:0.
- R5: While `chr_valid` is high and `chr_ready` is low, `chr_valid` and `chr_data` hold their values. On a clock edge where both are high, the character is taken and `chr_valid` falls.
- R6: `chr_busy` is high exactly while a character is pending. A terminal output write made while busy is dropped: the pending character is not replaced, and no second character follows it.
- R7: A terminal command other than 0x01, including input command 0x00, produces no character and changes no state.
- R8: A write whose device selector is anything other than 0x00 or 0x01 produces no character and no exit.
- R9: `rd_data` is always zero. `rd_ack` is high one cycle after each cycle in which `rd_en` is high.
- R10: After reset, `exit_req`, `exit_code`, `chr_valid`, `chr_busy` and `rd_ack` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the mailbox address |
| wr_data | input | 64 | Command word being written |
| rd_en | input | 1 | Read strobe for the mailbox address |
| rd_data | output | 64 | Read data, always zero |
| rd_ack | output | 1 | Read completion, one cycle after `rd_en` |
| exit_req | output | 1 | Sticky exit request |
| exit_code | output | 47 | Exit code taken from the first exit request |
| chr_valid | output | 1 | Output character is valid |
| chr_data | output | 8 | Output character |
| chr_ready | input | 1 | Downstream accepts the character |
| chr_busy | output | 1 | A character is pending |

## Verification
The assertions check on every cycle the following properties:
- the exit flag stays set and the exit code stays fixed once set;
- the output character holds under back-pressure;
- a terminal output write made while idle loads its byte;
- a write to an unknown device neither raises `chr_valid` nor sets the exit flag.

Other behaviour can only be shown by the bench's scenarios. The bench sweeps all 256 device selectors and all 256 terminal command codes, each from reset. It also shows that the first exit code wins over later ones. It shows that a write made while busy never produces a second character, even after the pending one drains. Finally, it shows the zero read data and the read acknowledge timing.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
  // Routing outcome of one decoded mailbox write.
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_EXIT = 2'd1,
    ACT_PUTC = 2'd2
  } act_e;

  // Device selector and command code values.
  localparam logic [7:0] DEV_PROXY = 8'h00;
  localparam logic [7:0] DEV_TERM  = 8'h01;
  localparam logic [7:0] TERM_IN   = 8'h00;
  localparam logic [7:0] TERM_OUT  = 8'h01;
endpackage

// File: rtl/hcmd_decode.sv
module hcmd_decode
  import hcmd_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned OP_W   = 8
) (
  input  logic                             wr_en,
  input  logic [WORD_W-1:0]                wr_data,
  output act_e                             act,
  output logic [WORD_W-SEL_W-OP_W-1:0]     pay
);
  localparam int unsigned PAY_W = WORD_W - SEL_W - OP_W;

  logic [SEL_W-1:0] dev;
  logic [OP_W-1:0]  op;

  assign dev = wr_data[WORD_W-1 -: SEL_W];
  assign op  = wr_data[PAY_W +: OP_W];
  assign pay = wr_data[PAY_W-1:0];

  always_comb begin
    act = ACT_NONE;
    if (wr_en) begin
      if (dev == SEL_W'(DEV_PROXY)) begin
        // Only payload bit 0 set means exit; otherwise the word is dropped.
        if (pay[0]) act = ACT_EXIT;
      end else if (dev == SEL_W'(DEV_TERM)) begin
        // Input command and unknown codes are taken but do nothing.
        if (op == OP_W'(TERM_OUT)) act = ACT_PUTC;
      end
    end
  end
endmodule

// File: rtl/hcmd_exit_latch.sv
module hcmd_exit_latch #(
  parameter int unsigned CODE_W = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [CODE_W-1:0] code_in,
  output logic              exit_req,
  output logic [CODE_W-1:0] exit_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exit_req  <= 1'b0;
      exit_code <= '0;
    end else if (set && !exit_req) begin
      // The first request wins; the flag holds until reset.
      exit_req  <= 1'b1;
      exit_code <= code_in;
    end
  end
endmodule

// File: rtl/hcmd_byte_out.sv
module hcmd_byte_out #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              valid,
  output logic [BYTE_W-1:0] data,
  input  logic              ready,
  output logic              busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (valid) begin
      // While a byte is pending, new loads are dropped.
      if (ready) valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= byte_in;
    end
  end

  assign busy = valid;
endmodule

// File: rtl/hcmd_mailbox.sv
module hcmd_mailbox
  import hcmd_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned OP_W   = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          rd_en,
  output logic [WORD_W-1:0]             rd_data,
  output logic                          rd_ack,
  output logic                          exit_req,
  output logic [WORD_W-SEL_W-OP_W-2:0]  exit_code,
  output logic                          chr_valid,
  output logic [BYTE_W-1:0]             chr_data,
  input  logic                          chr_ready,
  output logic                          chr_busy
);
  localparam int unsigned PAY_W  = WORD_W - SEL_W - OP_W;
  localparam int unsigned CODE_W = PAY_W - 1;

  act_e             act;
  logic [PAY_W-1:0] pay;

  hcmd_decode #(.WORD_W(WORD_W), .SEL_W(SEL_W), .OP_W(OP_W)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .act     (act),
    .pay     (pay)
  );

  hcmd_exit_latch #(.CODE_W(CODE_W)) u_exit (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (act == ACT_EXIT),
    .code_in   (pay[PAY_W-1:1]),
    .exit_req  (exit_req),
    .exit_code (exit_code)
  );

  hcmd_byte_out #(.BYTE_W(BYTE_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (act == ACT_PUTC),
    .byte_in (pay[BYTE_W-1:0]),
    .valid   (chr_valid),
    .data    (chr_data),
    .ready   (chr_ready),
    .busy    (chr_busy)
  );

  // No console input: reads complete with zero data.
  always_ff @(posedge clk) begin
    if (!rst_n) rd_ack <= 1'b0;
    else        rd_ack <= rd_en;
  end

  assign rd_data = '0;
endmodule

// File: rtl/hcmd_mailbox_chk.sv
module hcmd_mailbox_chk #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned OP_W   = 8,
  parameter int unsigned BYTE_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [WORD_W-1:0]            wr_data,
  input logic                         exit_req,
  input logic [WORD_W-SEL_W-OP_W-2:0] exit_code,
  input logic                         chr_valid,
  input logic [BYTE_W-1:0]            chr_data,
  input logic                         chr_ready
);
  localparam int unsigned PAY_W = WORD_W - SEL_W - OP_W;

  logic [SEL_W-1:0] dev;
  logic [OP_W-1:0]  op;

  assign dev = wr_data[WORD_W-1 -: SEL_W];
  assign op  = wr_data[PAY_W +: OP_W];

  AST_EXIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> exit_req); // R2

  AST_EXIT_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> $stable(exit_code)); // R2

  AST_CHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && !chr_ready) |=> (chr_valid && $stable(chr_data))); // R5

  AST_CHR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chr_valid && dev == SEL_W'(1) && op == OP_W'(1))
      |=> (chr_valid && chr_data == $past(wr_data[BYTE_W-1:0]))); // R4

  AST_UNKNOWN_NO_CHR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !chr_valid && dev > SEL_W'(1)) |=> !chr_valid); // R8

  AST_UNKNOWN_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !exit_req && dev != SEL_W'(0)) |=> !exit_req); // R8
endmodule

bind hcmd_mailbox hcmd_mailbox_chk #(
  .WORD_W(WORD_W), .SEL_W(SEL_W), .OP_W(OP_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .exit_req  (exit_req),
  .exit_code (exit_code),
  .chr_valid (chr_valid),
  .chr_data  (chr_data),
  .chr_ready (chr_ready)
);

// File: tb/sim_hcmd_mailbox.sv
`timescale 1ns/1ps
module sim_hcmd_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [63:0] rd_data;
  logic        rd_ack;
  logic        exit_req;
  logic [46:0] exit_code;
  logic        chr_valid;
  logic [7:0]  chr_data;
  logic        chr_ready = 1'b0;
  logic        chr_busy;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hcmd_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_ack(rd_ack),
    .exit_req(exit_req), .exit_code(exit_code),
    .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_ready(chr_ready), .chr_busy(chr_busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; chr_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [63:0] mk(input logic [7:0] dev, input logic [7:0] op,
                                     input logic [47:0] pay);
    return {dev, op, pay};
  endfunction

  // One-cycle write; returns at the next negedge, after the capturing edge.
  task automatic put(input logic [63:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    chr_ready = 1'b1;
    @(negedge clk);
    chr_ready = 1'b0;
  endtask

  initial begin
    logic [47:0] p1;
    logic [47:0] p2;
    do_reset();
    // R10: reset state
    chk("R10 exit_req", {63'd0, exit_req}, 64'd0);
    chk("R10 exit_code", {17'd0, exit_code}, 64'd0);
    chk("R10 chr_valid", {63'd0, chr_valid}, 64'd0);
    chk("R10 chr_busy", {63'd0, chr_busy}, 64'd0);
    chk("R10 rd_ack", {63'd0, rd_ack}, 64'd0);

    // Device sweep: R1, R4, R8
    for (int d = 0; d < 256; d++) begin
      logic [47:0] pl;
      pl = {8'(d), 32'h5A5A_0000, 8'((d * 7 + 3) | 1)};
      do_reset();
      put(mk(8'(d), 8'h01, pl));
      if (d == 0) begin
        chk("R1 exit set", {63'd0, exit_req}, 64'd1);
        chk("R1 exit code", {17'd0, exit_code}, {17'd0, pl[47:1]});
        chk("R8 no chr for proxy", {63'd0, chr_valid}, 64'd0);
      end else if (d == 1) begin
        chk("R4 chr valid", {63'd0, chr_valid}, 64'd1);
        chk("R4 chr data", {56'd0, chr_data}, {56'd0, pl[7:0]});
        chk("R6 busy while pending", {63'd0, chr_busy}, 64'd1);
        chk("R4 no exit", {63'd0, exit_req}, 64'd0);
      end else begin
        chk("R8 no chr", {63'd0, chr_valid}, 64'd0);
        chk("R8 no exit", {63'd0, exit_req}, 64'd0);
      end
    end

    // Terminal command sweep: R7, R4
    for (int c = 0; c < 256; c++) begin
      do_reset();
      put(mk(8'h01, 8'(c), 48'h0000_0000_0041 + 48'(c)));
      if (c == 1) begin
        chk("R4 out cmd", {63'd0, chr_valid}, 64'd1);
        chk("R4 out byte", {56'd0, chr_data}, 64'h42);
      end else begin
        chk("R7 no chr", {63'd0, chr_valid}, 64'd0);
        chk("R7 no busy", {63'd0, chr_busy}, 64'd0);
        chk("R7 no exit", {63'd0, exit_req}, 64'd0);
      end
    end

    // R3 then R2: proxy without bit 0, then two exits
    do_reset();
    put(mk(8'h00, 8'h00, 48'hFFFF_FFFF_FFFE));
    chk("R3 no exit", {63'd0, exit_req}, 64'd0);
    chk("R3 code unchanged", {17'd0, exit_code}, 64'd0);
    p1 = 48'h1234_5678_9ABD;
    p2 = 48'h0FED_CBA9_8765;
    put(mk(8'h00, 8'h37, p1));
    chk("R1 exit with any cmd", {63'd0, exit_req}, 64'd1);
    put(mk(8'h00, 8'h00, p2));
    chk("R2 first code kept", {17'd0, exit_code}, {17'd0, p1[47:1]});
    put(mk(8'h00, 8'h00, 48'h0));
    chk("R2 still set", {63'd0, exit_req}, 64'd1);
    repeat (5) @(negedge clk);
    chk("R2 sticky over idle", {63'd0, exit_req}, 64'd1);
    do_reset();
    chk("R2 reset clears", {63'd0, exit_req}, 64'd0);

    // R5 and R6: back-pressure and drop while busy
    put(mk(8'h01, 8'h01, 48'h0000_0000_00C3));
    put(mk(8'h01, 8'h01, 48'h0000_0000_003C));
    chk("R6 pending not replaced", {56'd0, chr_data}, 64'hC3);
    repeat (6) @(negedge clk);
    chk("R5 valid held", {63'd0, chr_valid}, 64'd1);
    chk("R5 data held", {56'd0, chr_data}, 64'hC3);
    drain();
    chk("R5 valid falls after accept", {63'd0, chr_valid}, 64'd0);
    chk("R6 busy clears", {63'd0, chr_busy}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R6 dropped byte never appears", {63'd0, chr_valid}, 64'd0);
    // Back-to-back bytes each after a drain
    for (int k = 0; k < 4; k++) begin
      put(mk(8'h01, 8'h01, 48'(k * 16 + 5)));
      chk("R4 sequential byte", {56'd0, chr_data}, 64'(k * 16 + 5));
      drain();
      chk("R5 drained", {63'd0, chr_valid}, 64'd0);
    end

    // R9: reads
    @(negedge clk);
    rd_en = 1'b1;
    chk("R9 rd_data zero", rd_data, 64'd0);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 rd_ack", {63'd0, rd_ack}, 64'd1);
    chk("R9 rd_data zero", rd_data, 64'd0);
    @(negedge clk);
    chk("R9 rd_ack drops", {63'd0, rd_ack}, 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule